// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch at fetch time. It holds two independent direction predictors. The first is indexed by a shift register of recent branch outcomes shared by all branches. The second is a two-level local scheme: the fetch PC picks a per-slot outcome history, and that history picks a 3-bit counter. A third table of 2-bit choice counters, indexed by the shared history, decides which of the two guesses is the final answer. The answer is combinational in the cycle the PC is presented.

Along with the guess, the block returns the shared history and the local history it used. The pipeline carries both down to execute and hands them back on the update port together with the branch PC and the resolved outcome. Only an update changes any table or history. A prediction request never changes state. The default sizes give 4096-entry shared and choice tables, 12 bits of shared history, 1024 local histories of 10 bits each, and 1024 local 3-bit counters, which is about 29 Kbit in total.

Top module: `tourn_predictor`

## Requirements
- R1: After reset, every 2-bit counter holds 1, every 3-bit counter holds 3, and all histories are zero, so the first prediction is not-taken with `pred_ghist` and `pred_lhist` both zero.
- R2: `pred_taken` follows `pred_pc` in the same cycle. It equals the local guess when the choice counter at the current shared history has its MSB set, and the shared-history guess otherwise.
- R3: A 2-bit counter predicts taken when its MSB is 1. A 3-bit counter predicts taken when its value is 4 or more.
- R4: Every counter saturates. An increment at the maximum and a decrement at zero leave it unchanged.
- R5: On an update, the outcome (1 = taken) enters bit 0 of the shared history and older bits move up one place, so bit i holds the outcome i updates back.
- R6: The local history slot is selected by `pc[LIDX_W+1:2]`. An update shifts its outcome into bit 0 of the slot for `upd_pc`, and only that slot changes.
- R7: The local 3-bit counter is indexed by the local history. On update, the counter at `upd_lhist` moves toward the outcome, and the shared counter at `upd_ghist` does the same.
- R8: The choice counter at `upd_ghist` changes only when the two component guesses read at the update indices differ. It increments when the local guess was right and decrements when the shared guess was right.
- R9: Without `upd_valid`, no counter and no history changes, whatever `pred_pc` does.
- R10: `pred_ghist` returns the current shared history, and `pred_lhist` returns the local history read for `pred_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ghist | output | GHIST_W | Shared history used for this prediction |
| pred_lhist | output | LHIST_W | Local history used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_ghist | input | GHIST_W | Shared history captured at prediction |
| upd_lhist | input | LHIST_W | Local history captured at prediction |

## Verification
The bench builds the block with PC_W=8, GHIST_W=4, LIDX_W=2 and LHIST_W=3, keeping LCNT_W=3. At these sizes the shared history wraps after four outcomes and a short run of taken branches drives counters into saturation. PCs 0x04 and 0x14 share a local history slot, so aliasing appears within a few dozen updates. The choice counters also reach the state where they select the local side, which needs the two components to disagree repeatedly at the same history value.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic {
        SEL_SHARED = 1'b0,
        SEL_LOCAL  = 1'b1
    } pick_e;

    // one saturating step, wide enough for any counter used here
    function automatic logic [7:0] sat_step(input logic [7:0] v,
                                            input logic       inc,
                                            input logic [7:0] top);
        if (inc) return (v == top)  ? v : v + 8'd1;
        else     return (v == 8'd0) ? v : v - 8'd1;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_val,
    input  logic [IDX_W-1:0] up_idx,
    output logic [CNT_W-1:0] up_val,
    input  logic             up_en,
    input  logic             up_inc
);
    localparam int               DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] INIT  = CNT_W'((1 << (CNT_W - 1)) - 1);
    localparam logic [CNT_W-1:0] MAXV  = '1;

    logic [CNT_W-1:0] mem [DEPTH];

    assign rd_val = mem[rd_idx];
    assign up_val = mem[up_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (up_en) begin
            mem[up_idx] <= CNT_W'(tp_pkg::sat_step(8'(up_val), up_inc, 8'(MAXV)));
        end
    end

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (up_en && up_inc && up_val == MAXV) |=> mem[$past(up_idx)] == MAXV);

    // R4
    sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (up_en && !up_inc && up_val == '0) |=> mem[$past(up_idx)] == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_en) |=> mem[$past(up_idx)] == $past(up_val));

endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_taken
);
    localparam int SLOTS = 1 << IDX_W;

    logic [HIST_W-1:0] hist [SLOTS];

    assign rd_hist = hist[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) hist[i] <= '0;
        end else if (up_en) begin
            hist[up_idx] <= {hist[up_idx][HIST_W-2:0], up_taken};
        end
    end

    // R6
    lhist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        up_en |=> hist[$past(up_idx)][0] == $past(up_taken));

endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor #(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 12,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int LCNT_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PC_W-1:0]    pred_pc,
    output logic               pred_taken,
    output logic [GHIST_W-1:0] pred_ghist,
    output logic [LHIST_W-1:0] pred_lhist,
    input  logic               upd_valid,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic               upd_taken,
    input  logic [GHIST_W-1:0] upd_ghist,
    input  logic [LHIST_W-1:0] upd_lhist
);
    import tp_pkg::*;

    localparam int SCNT_W = 2;

    typedef struct packed {
        logic  shared_dir;
        logic  local_dir;
        pick_e pick;
    } guess_t;

    logic [GHIST_W-1:0] ghist;
    logic [LIDX_W-1:0]  pred_slot, upd_slot;
    logic [SCNT_W-1:0]  g_rd, g_up, c_rd, c_up;
    logic [LCNT_W-1:0]  l_rd, l_up;
    logic [LHIST_W-1:0] lh_rd;
    guess_t             now_g, upd_g;
    logic               choice_en, choice_inc;

    assign pred_slot = pred_pc[LIDX_W+1:2];
    assign upd_slot  = upd_pc[LIDX_W+1:2];

    tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(SCNT_W)) u_shared (
        .clk(clk), .rst(rst),
        .rd_idx(ghist), .rd_val(g_rd),
        .up_idx(upd_ghist), .up_val(g_up),
        .up_en(upd_valid), .up_inc(upd_taken));

    tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(SCNT_W)) u_choice (
        .clk(clk), .rst(rst),
        .rd_idx(ghist), .rd_val(c_rd),
        .up_idx(upd_ghist), .up_val(c_up),
        .up_en(choice_en), .up_inc(choice_inc));

    tp_local_hist #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk(clk), .rst(rst),
        .rd_idx(pred_slot), .rd_hist(lh_rd),
        .up_en(upd_valid), .up_idx(upd_slot), .up_taken(upd_taken));

    tp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_local (
        .clk(clk), .rst(rst),
        .rd_idx(lh_rd), .rd_val(l_rd),
        .up_idx(upd_lhist), .up_val(l_up),
        .up_en(upd_valid), .up_inc(upd_taken));

    always_comb begin
        now_g.shared_dir = g_rd[SCNT_W-1];
        now_g.local_dir  = l_rd[LCNT_W-1];
        now_g.pick       = pick_e'(c_rd[SCNT_W-1]);
        upd_g.shared_dir = g_up[SCNT_W-1];
        upd_g.local_dir  = l_up[LCNT_W-1];
        upd_g.pick       = pick_e'(c_up[SCNT_W-1]);
    end

    assign pred_taken = (now_g.pick == SEL_LOCAL) ? now_g.local_dir : now_g.shared_dir;
    assign pred_ghist = ghist;
    assign pred_lhist = lh_rd;

    assign choice_en  = upd_valid && (upd_g.shared_dir != upd_g.local_dir);
    assign choice_inc = (upd_g.local_dir == upd_taken);

    always_ff @(posedge clk) begin
        if (rst)            ghist <= '0;
        else if (upd_valid) ghist <= {ghist[GHIST_W-2:0], upd_taken};
    end

    // R5
    ghist_new_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghist[0] == $past(upd_taken));

    // R5
    ghist_age_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0]));

    // R9
    ghist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghist));

endmodule

// File: tb/tourn_predictor_test.sv
module tourn_predictor_test;
    localparam int PC_W = 8, GW = 4, LI = 2, LH = 3, LC = 3;

    logic          clk = 0;
    logic          rst = 1;
    logic [PC_W-1:0] pred_pc = '0;
    logic          pred_taken;
    logic [GW-1:0] pred_ghist;
    logic [LH-1:0] pred_lhist;
    logic          upd_valid = 0;
    logic [PC_W-1:0] upd_pc = '0;
    logic          upd_taken = 0;
    logic [GW-1:0] upd_ghist = '0;
    logic [LH-1:0] upd_lhist = '0;

    int checks = 0;
    int errors = 0;

    // reference state
    int m_g [16];
    int m_c [16];
    int m_l [8];
    int m_lht [4];
    int m_gh;

    always #5 clk = ~clk;

    tourn_predictor #(.PC_W(PC_W), .GHIST_W(GW), .LIDX_W(LI), .LHIST_W(LH), .LCNT_W(LC)) uut (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_ghist(pred_ghist), .pred_lhist(pred_lhist), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_ghist(upd_ghist), .upd_lhist(upd_lhist));

    // {pc, outcome}; 0x04 and 0x14 alias in the local slot
    localparam logic [8:0] VEC [32] = '{
        {8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b0},{8'h08,1'b1},
        {8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b0},{8'h08,1'b1},
        {8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b0},{8'h08,1'b1},
        {8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b1},{8'h08,1'b0},{8'h04,1'b0},{8'h08,1'b1},
        {8'h14,1'b1},{8'h14,1'b1},{8'h14,1'b0},{8'h14,1'b1},
        {8'h04,1'b1},{8'h04,1'b1},{8'h04,1'b1},{8'h04,1'b0}};

    function automatic int sat(input int v, input bit inc, input int top);
        if (inc) return (v == top) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_g[i] = 1; m_c[i] = 1; end
        for (int i = 0; i < 8; i++) m_l[i] = 3;
        for (int i = 0; i < 4; i++) m_lht[i] = 0;
        m_gh = 0;
    endtask

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int exp_pred(input logic [7:0] pc);
        int lh;
        lh = m_lht[pc[3:2]];
        if (m_c[m_gh] >= 2) return (m_l[lh] >= 4) ? 1 : 0;
        return (m_g[m_gh] >= 2) ? 1 : 0;
    endfunction

    task automatic step(input logic [7:0] pc, input bit tk, input string tag);
        int gi, li, gp, lp;
        @(negedge clk);
        pred_pc = pc;
        #1;
        gi = m_gh;
        li = m_lht[pc[3:2]];
        check(int'(pred_taken), exp_pred(pc), {tag, " R2 R3 R7 R8 pred_taken"});
        check(int'(pred_ghist), gi, "R5 R10 pred_ghist");
        check(int'(pred_lhist), li, "R6 R10 pred_lhist");
        upd_valid = 1; upd_pc = pc; upd_taken = tk;
        upd_ghist = pred_ghist; upd_lhist = pred_lhist;
        gp = (m_g[gi] >= 2); lp = (m_l[li] >= 4);
        m_g[gi] = sat(m_g[gi], tk, 3);
        m_l[li] = sat(m_l[li], tk, 7);
        if (gp != lp) m_c[gi] = sat(m_c[gi], (lp == int'(tk)), 3);
        m_gh = ((m_gh << 1) | int'(tk)) & 15;
        m_lht[pc[3:2]] = ((m_lht[pc[3:2]] << 1) | int'(tk)) & 7;
        @(posedge clk);
        #1 upd_valid = 0;
    endtask

    task automatic do_reset();
        rst = 1; upd_valid = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        model_reset();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        @(negedge clk); pred_pc = 8'h04; #1;
        check(int'(pred_taken), 0, "R1 pred_taken after reset");
        check(int'(pred_ghist), 0, "R1 pred_ghist after reset");
        check(int'(pred_lhist), 0, "R1 pred_lhist after reset");

        for (int k = 0; k < 32; k++) step(VEC[k][8:1], VEC[k][0], "vec");

        // R9: predictions without update leave state alone
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); pred_pc = 8'(k * 4); #1;
            check(int'(pred_ghist), m_gh, "R9 pred_ghist idle");
            check(int'(pred_lhist), m_lht[k], "R9 pred_lhist idle");
            check(int'(pred_taken), exp_pred(8'(k * 4)), "R9 pred_taken idle");
        end

        // R4: long taken run saturates counters, then not-taken runs to the floor
        for (int k = 0; k < 12; k++) step(8'h0c, 1'b1, "R4 up");
        for (int k = 0; k < 12; k++) step(8'h0c, 1'b0, "R4 down");
        for (int k = 0; k < 6; k++) step(8'h0c, k[0], "R4 mix");

        // R1 again after reset mid-run
        do_reset();
        @(negedge clk); pred_pc = 8'h0c; #1;
        check(int'(pred_taken), 0, "R1 pred_taken after second reset");
        check(int'(pred_ghist), 0, "R1 pred_ghist after second reset");
        check(int'(pred_lhist), 0, "R1 pred_lhist after second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule